// File: doc/BRIEF.md
# Double-Buffered Octal DAC Register Front End

This block is the digital front end of an eight-channel, 12-bit digital-to-analog converter. A host talks to it over a parallel bus. The bus has an active-low chip select, a read/write line, a 5-bit address, and separate 12-bit data-in and data-out paths with an output enable. Each channel has three stages. The first is an input register written by the host. The second is an optional correction stage. The third is an output latch that drives the converter code. The block decides when input data moves into the output latches.

The update mode is taken from the level of the load pin while power-on reset is held. A low level gives asynchronous mode, where every write reaches the outputs without a separate load. A high level gives synchronous mode, where all latches move together on a load pin pulse or on a software load bit. A format pin lets the host write and read channel data in two's complement. A hardware reset loads a selectable code, and a clear input forces every output to zero code. When correction is enabled, a fixed-length pass adds a signed per-channel offset to the data and saturates the result. The busy flag is held low during the pass, and any load request waits for the pass to finish.

Top module: `dac_regif_top`

## Requirements
- R1: The level of `load_n` during power-on reset (`rst` high) fixes the mode for the rest of the run: low selects asynchronous mode, where a channel write reaches `dac_out` within three clock cycles without any load request; high selects synchronous mode.
- R2: A write (`rw`=0) commits the address and data sampled in the last clock cycle before `cs_n` is seen high again. While `cs_n` is low with `rw`=1, `data_oe` is high and `dout` carries the addressed register. `data_oe` is low whenever `cs_n` is high.
- R3: Address map: 0x00 config (bit0 load request, bit1 correction enable; a read gives bit1 in place and bit0 as 0), 0x01 general-purpose register, 0x02 monitor select (its low 5 bits appear on `mon_sel`), 0x08+n channel n data, 0x10+n channel n signed zero offset. Channel n occupies `dac_out[12n+11:12n]`.
- R4: In synchronous mode, `dac_out` keeps its value after channel writes until `load_n` is sampled low, and then all channels take their new codes in the same cycle.
- R5: Writing config bit0 as 1 has the same effect as a load pin pulse, and the bit never reads back as 1.
- R6: With `fmt_twos`=1, channel data is converted by inverting bit 11 on both write and read. With `fmt_twos`=0 it passes unchanged. Config, general-purpose, monitor and offset registers are never converted.
- R7: `hw_rst_n` low while `cs_n` is high sets every input register, correction result and output latch to 000h when `rst_sel`=0 or to 800h when `rst_sel`=1. While `cs_n` is low, `hw_rst_n` has no effect.
- R8: While `clr_n` is low, every channel of `dac_out` reads 000h. When `clr_n` returns high, the latch values are shown again unchanged.
- R9: With correction enabled, a write to a channel, an offset or the config register with bit1 set starts a pass. `busy_n` goes low from the commit edge for CORR_CYCLES cycles. After the pass, each channel's source code is its input code plus its signed offset.
- R10: A load request (pin or bit) that arrives while `busy_n` is low leaves the output latches unchanged during the pass and is carried out once the pass ends.
- R11: The corrected code saturates at 000h below zero and at FFFh above 4095.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| cs_n | input | 1 | Chip select, active low |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | 5 | Register address |
| din | input | 12 | Write data from host |
| dout | output | 12 | Read data to host |
| data_oe | output | 1 | Drive enable for the host data bus |
| load_n | input | 1 | Load request pin, active low; mode strap at power-on |
| fmt_twos | input | 1 | Channel data in two's complement when high |
| hw_rst_n | input | 1 | Hardware reset, active low, honoured only with cs_n high |
| rst_sel | input | 1 | Reset code select: 0 = 000h, 1 = 800h |
| clr_n | input | 1 | Clear, active low, forces outputs to 000h |
| busy_n | output | 1 | Low while a correction pass runs |
| mon_sel | output | 5 | Monitor select field |
| dac_out | output | 96 | Eight packed 12-bit output codes |

## Verification
The bench builds the block with its default eight channels and a four-cycle correction pass. With these values every channel address and every offset slot can be swept, and each pass is short enough that a load request can be placed inside it on purpose. The bench applies power-on reset twice, once with the load pin low and once with it high, so that both update modes are reached in one run. It also drives offsets that push the sum past both ends of the code range.

// File: rtl/dac_regif_pkg.sv
package dac_regif_pkg;

    localparam int CODE_W = 12;
    localparam int ADDR_W = 5;
    localparam int MON_W  = 5;

    localparam logic [ADDR_W-1:0] ADR_CFG  = 5'h00;
    localparam logic [ADDR_W-1:0] ADR_GPR  = 5'h01;
    localparam logic [ADDR_W-1:0] ADR_MON  = 5'h02;
    localparam logic [1:0]        PAGE_CH  = 2'b01;
    localparam logic [1:0]        PAGE_OFS = 2'b10;

    localparam int CFG_LOAD_BIT = 0;
    localparam int CFG_CORR_BIT = 1;

    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        code_t             data;
    } bus_wr_t;

    function automatic code_t fmt_swap(input code_t v, input logic twos);
        fmt_swap = {v[CODE_W-1] ^ twos, v[CODE_W-2:0]};
    endfunction

    function automatic code_t reset_code(input logic mid);
        reset_code = mid ? {1'b1, {(CODE_W-1){1'b0}}} : '0;
    endfunction

    function automatic code_t sat_add(input code_t base, input code_t ofs);
        logic signed [CODE_W+1:0] sum;
        sum = $signed({2'b00, base}) + $signed({{2{ofs[CODE_W-1]}}, ofs});
        if (sum < 0)
            sat_add = '0;
        else if (sum > $signed({2'b00, {CODE_W{1'b1}}}))
            sat_add = '1;
        else
            sat_add = sum[CODE_W-1:0];
    endfunction

endpackage

// File: rtl/dac_bus_capture.sv
module dac_bus_capture
    import dac_regif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              rw,
    input  logic [ADDR_W-1:0] addr,
    input  code_t             din,
    output bus_wr_t           wr
);
    logic              cs_n_q;
    logic              rw_q;
    logic [ADDR_W-1:0] addr_q;
    code_t             din_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_n_q <= 1'b1;
            rw_q   <= 1'b1;
            addr_q <= '0;
            din_q  <= '0;
        end else begin
            cs_n_q <= cs_n;
            if (!cs_n) begin
                rw_q   <= rw;
                addr_q <= addr;
                din_q  <= din;
            end
        end
    end

    always_comb begin
        wr.valid = !cs_n_q && cs_n && !rw_q && !rst;
        wr.addr  = addr_q;
        wr.data  = din_q;
    end

endmodule

// File: rtl/dac_corr_engine.sv
module dac_corr_engine
    import dac_regif_pkg::*;
#(
    parameter int NCH         = 8,
    parameter int CORR_CYCLES = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  hw_clr,
    input  code_t                 clr_code,
    input  logic                  start,
    input  logic [NCH-1:0][CODE_W-1:0] in_codes,
    input  logic [NCH-1:0][CODE_W-1:0] ofs_codes,
    output logic [NCH-1:0][CODE_W-1:0] corr_codes,
    output logic                  busy
);
    localparam int CNT_W = $clog2(CORR_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(CORR_CYCLES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || hw_clr) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= CNT_LOAD;
        end else if (cnt != '0) begin
            cnt <= cnt - CNT_LAST;
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst || hw_clr) begin
                corr_codes[g] <= clr_code;
            end else if (!start && cnt == CNT_LAST) begin
                corr_codes[g] <= sat_add(in_codes[g], ofs_codes[g]);
            end
        end
    end

    assign busy = (cnt != '0);

endmodule

// File: rtl/dac_latch_ctrl.sv
module dac_latch_ctrl
    import dac_regif_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load_n,
    input  logic                  ld_bit,
    input  logic                  busy,
    input  logic                  hw_clr,
    input  code_t                 clr_code,
    input  logic [NCH-1:0][CODE_W-1:0] src_codes,
    output logic [NCH-1:0][CODE_W-1:0] latch_codes,
    output logic                  async_mode
);
    logic trig;
    logic pend;
    logic xfer;

    assign trig = !load_n || ld_bit;
    assign xfer = (async_mode || trig || pend) && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            async_mode <= !load_n;
            pend       <= 1'b0;
        end else if (hw_clr || xfer) begin
            pend <= 1'b0;
        end else if (trig) begin
            pend <= 1'b1;
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_latch
        always_ff @(posedge clk) begin
            if (rst || hw_clr) begin
                latch_codes[g] <= clr_code;
            end else if (xfer) begin
                latch_codes[g] <= src_codes[g];
            end
        end
    end

endmodule

// File: rtl/dac_regif_top.sv
module dac_regif_top
    import dac_regif_pkg::*;
#(
    parameter int NCH         = 8,
    parameter int CORR_CYCLES = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cs_n,
    input  logic                  rw,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [CODE_W-1:0]     din,
    output logic [CODE_W-1:0]     dout,
    output logic                  data_oe,
    input  logic                  load_n,
    input  logic                  fmt_twos,
    input  logic                  hw_rst_n,
    input  logic                  rst_sel,
    input  logic                  clr_n,
    output logic                  busy_n,
    output logic [MON_W-1:0]      mon_sel,
    output logic [NCH*CODE_W-1:0] dac_out
);
    localparam int CIW = (NCH > 1) ? $clog2(NCH) : 1;

    bus_wr_t wr;
    code_t   rcode;
    logic    hw_clr;
    logic    corr_en;
    code_t   gpr_reg;
    code_t   mon_reg;
    logic    busy;
    logic    async_mode;
    logic    ld_bit;
    logic    corr_start;
    logic    wr_ch;
    logic    wr_ofs;
    logic    wr_cfg;
    logic [CIW-1:0] wr_idx;
    logic [CIW-1:0] rd_idx;

    logic [NCH-1:0][CODE_W-1:0] in_reg;
    logic [NCH-1:0][CODE_W-1:0] ofs_reg;
    logic [NCH-1:0][CODE_W-1:0] corr_codes;
    logic [NCH-1:0][CODE_W-1:0] src_codes;
    logic [NCH-1:0][CODE_W-1:0] latch_codes;
    logic [NCH*CODE_W-1:0]      latch_flat;

    assign rcode  = reset_code(rst_sel);
    assign hw_clr = !hw_rst_n && cs_n && !rst;

    dac_bus_capture u_bus (
        .clk  (clk),
        .rst  (rst),
        .cs_n (cs_n),
        .rw   (rw),
        .addr (addr),
        .din  (din),
        .wr   (wr)
    );

    assign wr_idx = wr.addr[CIW-1:0];
    assign wr_cfg = wr.valid && (wr.addr == ADR_CFG);
    assign wr_ch  = wr.valid && (wr.addr[ADDR_W-1:ADDR_W-2] == PAGE_CH)
                    && (32'(wr_idx) < NCH);
    assign wr_ofs = wr.valid && (wr.addr[ADDR_W-1:ADDR_W-2] == PAGE_OFS)
                    && (32'(wr_idx) < NCH);
    assign ld_bit = wr_cfg && wr.data[CFG_LOAD_BIT];

    assign corr_start = !hw_clr &&
                        ((corr_en && (wr_ch || wr_ofs)) ||
                         (wr_cfg && wr.data[CFG_CORR_BIT]));

    always_ff @(posedge clk) begin
        if (rst) begin
            corr_en <= 1'b0;
            gpr_reg <= '0;
            mon_reg <= '0;
        end else if (wr.valid) begin
            if (wr.addr == ADR_CFG) corr_en <= wr.data[CFG_CORR_BIT];
            if (wr.addr == ADR_GPR) gpr_reg <= wr.data;
            if (wr.addr == ADR_MON) mon_reg <= wr.data;
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_regs
        always_ff @(posedge clk) begin
            if (rst || hw_clr) begin
                in_reg[g] <= rcode;
            end else if (wr_ch && (32'(wr_idx) == g)) begin
                in_reg[g] <= fmt_swap(wr.data, fmt_twos);
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                ofs_reg[g] <= '0;
            end else if (wr_ofs && (32'(wr_idx) == g)) begin
                ofs_reg[g] <= wr.data;
            end
        end

        assign src_codes[g] = corr_en ? corr_codes[g] : in_reg[g];
        assign latch_flat[g*CODE_W +: CODE_W] = latch_codes[g];
        assign dac_out[g*CODE_W +: CODE_W]    = clr_n ? latch_codes[g] : '0;
    end

    dac_corr_engine #(
        .NCH         (NCH),
        .CORR_CYCLES (CORR_CYCLES)
    ) u_corr (
        .clk        (clk),
        .rst        (rst),
        .hw_clr     (hw_clr),
        .clr_code   (rcode),
        .start      (corr_start),
        .in_codes   (in_reg),
        .ofs_codes  (ofs_reg),
        .corr_codes (corr_codes),
        .busy       (busy)
    );

    dac_latch_ctrl #(
        .NCH (NCH)
    ) u_latch (
        .clk         (clk),
        .rst         (rst),
        .load_n      (load_n),
        .ld_bit      (ld_bit),
        .busy        (busy),
        .hw_clr      (hw_clr),
        .clr_code    (rcode),
        .src_codes   (src_codes),
        .latch_codes (latch_codes),
        .async_mode  (async_mode)
    );

    assign rd_idx = addr[CIW-1:0];

    always_comb begin
        dout = '0;
        if (addr == ADR_CFG) begin
            dout[CFG_CORR_BIT] = corr_en;
        end else if (addr == ADR_GPR) begin
            dout = gpr_reg;
        end else if (addr == ADR_MON) begin
            dout = mon_reg;
        end else if (addr[ADDR_W-1:ADDR_W-2] == PAGE_CH && 32'(rd_idx) < NCH) begin
            dout = fmt_swap(in_reg[rd_idx], fmt_twos);
        end else if (addr[ADDR_W-1:ADDR_W-2] == PAGE_OFS && 32'(rd_idx) < NCH) begin
            dout = ofs_reg[rd_idx];
        end
    end

    assign data_oe = !cs_n && rw;
    assign busy_n  = !busy;
    assign mon_sel = mon_reg[MON_W-1:0];

endmodule

// File: rtl/dac_regif_chk.sv
module dac_regif_chk
    import dac_regif_pkg::*;
#(
    parameter int NCH = 8
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  cs_n,
    input logic                  hw_rst_n,
    input logic                  rst_sel,
    input logic                  clr_n,
    input logic                  busy_n,
    input logic                  data_oe,
    input logic                  async_mode,
    input logic [NCH*CODE_W-1:0] dac_out,
    input logic [NCH*CODE_W-1:0] latch_flat
);
    code_t pat;
    assign pat = rst_sel ? 12'h800 : 12'h000;

    a_r1_mode_fixed: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(async_mode));

    a_r2_bus_released: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !data_oe);

    a_r7_hw_reset_code: assert property (@(posedge clk) disable iff (rst)
        (!hw_rst_n && cs_n) |=> (latch_flat == {NCH{$past(pat)}}));

    a_r8_clear_zero: assert property (@(posedge clk) disable iff (rst)
        !clr_n |-> (dac_out == '0));

    a_r10_hold_while_busy: assert property (@(posedge clk) disable iff (rst)
        (!busy_n && (hw_rst_n || !cs_n)) |=> $stable(latch_flat));

endmodule

bind dac_regif_top dac_regif_chk #(.NCH(NCH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cs_n       (cs_n),
    .hw_rst_n   (hw_rst_n),
    .rst_sel    (rst_sel),
    .clr_n      (clr_n),
    .busy_n     (busy_n),
    .data_oe    (data_oe),
    .async_mode (async_mode),
    .dac_out    (dac_out),
    .latch_flat (latch_flat)
);

// File: tb/dac_regif_top_tb.sv
module dac_regif_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NCH  = 8;
    localparam int CORR = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1;
    logic        rw = 1'b1;
    logic [4:0]  addr = '0;
    logic [11:0] din = '0;
    logic [11:0] dout;
    logic        data_oe;
    logic        load_n = 1'b0;
    logic        fmt_twos = 1'b0;
    logic        hw_rst_n = 1'b1;
    logic        rst_sel = 1'b0;
    logic        clr_n = 1'b1;
    logic        busy_n;
    logic [4:0]  mon_sel;
    logic [NCH*12-1:0] dac_out;

    int errors = 0;
    int checks = 0;
    logic [11:0] expv [NCH];

    always #(CLK_PERIOD/2) clk = ~clk;

    dac_regif_top #(.NCH(NCH), .CORR_CYCLES(CORR)) u_dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rw(rw), .addr(addr), .din(din),
        .dout(dout), .data_oe(data_oe), .load_n(load_n), .fmt_twos(fmt_twos),
        .hw_rst_n(hw_rst_n), .rst_sel(rst_sel), .clr_n(clr_n),
        .busy_n(busy_n), .mon_sel(mon_sel), .dac_out(dac_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [11:0] d);
        @(negedge clk); addr = a; din = d; rw = 1'b0; cs_n = 1'b0;
        @(negedge clk); cs_n = 1'b1;
        @(negedge clk); rw = 1'b1;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [11:0] d, output logic oe);
        @(negedge clk); addr = a; rw = 1'b1; cs_n = 1'b0;
        #1 d = dout; oe = data_oe;
        @(negedge clk); cs_n = 1'b1;
    endtask

    function automatic logic [11:0] chan(input int n);
        return dac_out[n*12 +: 12];
    endfunction

    function automatic logic [11:0] sat(input logic [11:0] b, input logic [11:0] o);
        int s;
        s = int'(b) + (o[11] ? int'(o) - 4096 : int'(o));
        if (s < 0) return 12'h000;
        if (s > 4095) return 12'hFFF;
        return 12'(s);
    endfunction

    function automatic logic [11:0] pat_data(input int n);
        if (n == 0) return 12'hFF0;
        if (n == 1) return 12'h010;
        return 12'((n * 12'h233 + 12'h040) & 12'hFFF);
    endfunction

    function automatic logic [11:0] pat_ofs(input int n);
        if (n == 0) return 12'h020;
        if (n == 1) return 12'hFE0;
        return 12'((n * 37 - 100) & 12'hFFF);
    endfunction

    task automatic power_on(input logic strap);
        @(negedge clk); rst = 1'b1; load_n = strap; rst_sel = 1'b0;
        ticks(3);
        rst = 1'b0;
        ticks(1);
        load_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [11:0] rd;
        logic oe;

        // ---------- asynchronous mode ----------
        power_on(1'b0);
        load_n = 1'b0;
        for (int n = 0; n < NCH; n++) chk("R7 reset code 000h", chan(n), 0);
        chk("R2 bus released at idle", data_oe, 0);
        chk("R9 idle busy_n", busy_n, 1);

        for (int n = 0; n < NCH; n++) begin
            logic [11:0] v = 12'((n * 12'h1F3 + 12'h111) & 12'hFFF);
            bus_write(5'h08 + 5'(n), v);
            ticks(2);
            chk("R1 async write reaches output", chan(n), v);
            bus_read(5'h08 + 5'(n), rd, oe);
            chk("R2 read drives enable", oe, 1);
            chk("R3 channel readback", rd, v);
        end

        fmt_twos = 1'b1;
        for (int n = 0; n < NCH; n += 3) begin
            logic [11:0] v = 12'h7A0 + 12'(n);
            bus_write(5'h08 + 5'(n), v);
            ticks(2);
            chk("R6 twos input inverted MSB", chan(n), v ^ 12'h800);
            bus_read(5'h08 + 5'(n), rd, oe);
            chk("R6 twos readback", rd, v);
        end
        bus_write(5'h01, 12'hA5C);
        bus_read(5'h01, rd, oe);
        chk("R6 command reg not converted", rd, 12'hA5C);
        fmt_twos = 1'b0;

        bus_write(5'h02, 12'h3F5);
        ticks(1);
        chk("R3 monitor select field", mon_sel, 5'h15);
        bus_read(5'h02, rd, oe);
        chk("R3 monitor readback", rd, 12'h3F5);

        for (int n = 0; n < NCH; n++) expv[n] = chan(n);
        clr_n = 1'b0;
        ticks(2);
        for (int n = 0; n < NCH; n++) chk("R8 clear forces zero", chan(n), 0);
        clr_n = 1'b1;
        ticks(2);
        for (int n = 0; n < NCH; n++) chk("R8 values return after clear", chan(n), expv[n]);

        rst_sel = 1'b1;
        @(negedge clk); addr = 5'h08; rw = 1'b1; cs_n = 1'b0; hw_rst_n = 1'b0;
        @(negedge clk); hw_rst_n = 1'b1;
        @(negedge clk); cs_n = 1'b1;
        ticks(2);
        for (int n = 0; n < NCH; n++) chk("R7 reset ignored with cs low", chan(n), expv[n]);
        @(negedge clk); hw_rst_n = 1'b0;
        @(negedge clk); hw_rst_n = 1'b1;
        ticks(2);
        for (int n = 0; n < NCH; n++) chk("R7 reset to midscale", chan(n), 12'h800);
        bus_read(5'h0B, rd, oe);
        chk("R7 input reg midscale", rd, 12'h800);

        // correction with saturation sweep
        for (int n = 0; n < NCH; n++) bus_write(5'h10 + 5'(n), pat_ofs(n));
        bus_read(5'h11, rd, oe);
        chk("R3 offset readback", rd, pat_ofs(1));
        bus_write(5'h00, 12'h002);
        chk("R9 busy after enable", busy_n, 0);
        bus_read(5'h00, rd, oe);
        chk("R3 config readback", rd, 12'h002);
        for (int n = 0; n < NCH; n++) begin
            bus_write(5'h08 + 5'(n), pat_data(n));
            chk("R9 busy during pass", busy_n, 0);
        end
        ticks(CORR + 3);
        chk("R9 busy released", busy_n, 1);
        chk("R11 saturate high", chan(0), 12'hFFF);
        chk("R11 saturate low", chan(1), 12'h000);
        for (int n = 2; n < NCH; n++)
            chk("R9 corrected code", chan(n), sat(pat_data(n), pat_ofs(n)));

        // ---------- synchronous mode ----------
        power_on(1'b1);
        for (int n = 0; n < NCH; n++) bus_write(5'h08 + 5'(n), 12'h100 + 12'(n * 17));
        ticks(3);
        for (int n = 0; n < NCH; n++) chk("R4 sync holds before load", chan(n), 0);
        @(negedge clk); load_n = 1'b0;
        @(negedge clk); load_n = 1'b1;
        for (int n = 0; n < NCH; n++) chk("R4 all channels on load", chan(n), 12'h100 + 12'(n * 17));

        for (int n = 0; n < NCH; n++) bus_write(5'h08 + 5'(n), 12'hC00 - 12'(n * 5));
        ticks(3);
        chk("R4 sync holds second batch", chan(4), 12'h100 + 12'(4 * 17));
        bus_write(5'h00, 12'h001);
        ticks(1);
        for (int n = 0; n < NCH; n++) chk("R5 load bit updates", chan(n), 12'hC00 - 12'(n * 5));
        bus_read(5'h00, rd, oe);
        chk("R5 load bit reads zero", rd, 0);

        bus_write(5'h12, 12'h005);
        bus_write(5'h00, 12'h002);
        ticks(CORR + 3);
        expv[2] = chan(2);
        bus_write(5'h0A, 12'h100);
        chk("R9 busy after channel write", busy_n, 0);
        load_n = 1'b0;
        @(negedge clk); load_n = 1'b1;
        chk("R10 no update while busy", chan(2), expv[2]);
        ticks(CORR + 3);
        chk("R10 deferred load applied", chan(2), 12'h105);
        chk("R9 other channel corrected", chan(3), sat(12'hC00 - 12'd15, 12'h000));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule